// File: doc/BRIEF.md
# Card Window Address Mapper and Strobe Sequencer

This block sits between a host request/acknowledge port and a removable-card bus. The host address is split into a window index (the bits above the low 20) and a 20-bit offset. Each of three windows carries its own pair of 16-bit configuration words. These words give a 1 MB page base inside a 64 MB card space, a choice of card address space (attribute memory, common memory or I/O), and the bus timing for that window. When the host addresses a valid window, the block forms the 26-bit card address from the page base and the offset. It raises one space-select line and runs the card command strobe through a fixed sequence. Once the sequence ends it acknowledges the host.

The sequencer has seven named states. IDLE waits for a request. SETUP drives address and select ahead of the strobe. STROBE drives the command strobe. WAIT stretches the strobe while the card holds its wait line. TMO marks a stretch that ran past its limit. RECOVER keeps the card idle between accesses. DONE acknowledges the host.

The transitions are:
- IDLE→SETUP on a request that hits a window while the card port is enabled.
- IDLE→DONE on a request that misses every window or arrives with the port disabled.
- SETUP→STROBE when the setup count expires.
- STROBE→WAIT when the wait line is sampled high.
- STROBE→RECOVER when the strobe count expires.
- WAIT→STROBE or WAIT→RECOVER when the wait line drops.
- WAIT→TMO when the stretch limit is reached.
- TMO→RECOVER, RECOVER→DONE and DONE→IDLE.

Top module: `card_window_mapper`

## Requirements
- R1: After reset, host_ack, host_err, card_cmd, card_timeout and all three select lines are low.
- R2: host_addr[21:20] picks window 0, 1 or 2. card_addr is {base, host_addr[19:0]}, where base is bits 5:0 of that window's first control word.
- R3: Bits 7:6 of the first control word choose the space: 00 attribute, 01 common, 10 I/O, 11 common. Exactly one select line is high during SETUP, STROBE and WAIT, and none is high at other times.
- R4: SETUP lasts delay+1 cycles, with delay taken from bits 9:8 of the first word. The select line is high and the strobe low during SETUP.
- R5: With no wait stretch, card_cmd stays high for length+1 consecutive cycles, with length taken from bits 14:10 of the first word.
- R6: RECOVER lasts recovery+1 cycles, with recovery taken from bits 4:3 of the second word. Select and strobe are low in RECOVER. For an unstretched access, host_ack rises delay+length+recovery+4 cycles after the request is taken, is one cycle wide, and host_err is low with it.
- R7: Bit 0 of the second word enables wait handling. When it is set, card_wait is sampled on strobe cycle min(wdelay, length), counted from 0, with wdelay taken from bits 2:1. A high sample holds the strobe until card_wait is seen low, and the rest of the strobe then completes.
- R8: When bit 0 of the second word is clear, card_wait has no effect on strobe length or acknowledge timing.
- R9: A stretch that lasts 256 cycles ends the strobe. card_timeout then pulses for one cycle, recovery runs, and the access is acknowledged with host_err high.
- R10: A request to window index 3, or any request while port_en is low, is acknowledged with host_err high on the cycle after it is taken. No select or strobe is driven.
- R11: card_addr is held constant for the whole time card_cmd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Card interface enabled |
| win_ctl_a | input | 48 | First control word of each window, window w at bits 16w+15:16w |
| win_ctl_b | input | 48 | Second control word of each window, same packing |
| host_req | input | 1 | Host request, held until acknowledged |
| host_addr | input | 22 | Host address: window index over a 20-bit offset |
| host_ack | output | 1 | One-cycle acknowledge |
| host_err | output | 1 | Error qualifier for host_ack |
| card_addr | output | 26 | Card address |
| card_sel_attr | output | 1 | Attribute memory select |
| card_sel_comm | output | 1 | Common memory select |
| card_sel_io | output | 1 | I/O space select |
| card_cmd | output | 1 | Command strobe |
| card_wait | input | 1 | Card wait request |
| card_timeout | output | 1 | One-cycle wait timeout pulse |

## Verification
Some properties are checked on every cycle:
- At most one select line is high, and exactly one is high while the strobe is active.
- The acknowledge and the timeout are single-cycle pulses.
- The card address does not move while the strobe is active.
- The strobe is always preceded by a select.
- The acknowledge never overlaps a select or the strobe.

Other behaviour can only be shown by the directed scenarios. These cover the exact cycle counts of setup, strobe and recovery for each window's timing, the page-base concatenation, and the 11 space alias. They also cover where the wait sample falls, including a wait delay longer than the strobe, that wait is ignored when wait handling is off, the 256-cycle stretch limit, and the error acknowledge for a missed window or a disabled port.

// File: rtl/card_win_pkg.sv
package card_win_pkg;

    localparam int BASE_W = 6;
    localparam int LEN_W  = 5;
    localparam int TIM_W  = 2;
    localparam int CTL_W  = 16;

    typedef enum logic [1:0] {
        SP_ATTR = 2'b00,
        SP_COMM = 2'b01,
        SP_IO   = 2'b10,
        SP_ALT  = 2'b11
    } space_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        space_e            space;
        logic [TIM_W-1:0]  dly;
        logic [LEN_W-1:0]  len;
        logic [TIM_W-1:0]  rec;
        logic [TIM_W-1:0]  wdly;
        logic              wreq;
    } win_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT,
        ST_TMO,
        ST_RECOVER,
        ST_DONE
    } seq_state_e;

    function automatic win_cfg_t unpack_cfg(input logic [CTL_W-1:0] wa,
                                            input logic [CTL_W-1:0] wb);
        win_cfg_t c;
        c.base  = wa[5:0];
        c.space = space_e'(wa[7:6]);
        c.dly   = wa[9:8];
        c.len   = wa[14:10];
        c.rec   = wb[4:3];
        c.wdly  = wb[2:1];
        c.wreq  = wb[0];
        return c;
    endfunction

endpackage

// File: rtl/card_win_decode.sv
module card_win_decode
    import card_win_pkg::*;
#(
    parameter int NWIN      = 3,
    parameter int PAGE_BITS = 20,
    parameter int WSEL_W    = 2
) (
    input  logic [NWIN*CTL_W-1:0]        ctl_a,
    input  logic [NWIN*CTL_W-1:0]        ctl_b,
    input  logic [WSEL_W+PAGE_BITS-1:0]  addr,
    output logic                         hit,
    output win_cfg_t                     cfg
);
    logic [WSEL_W-1:0] idx;
    win_cfg_t          per_win [NWIN];

    assign idx = addr[WSEL_W+PAGE_BITS-1:PAGE_BITS];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign per_win[w] = unpack_cfg(ctl_a[w*CTL_W +: CTL_W],
                                       ctl_b[w*CTL_W +: CTL_W]);
    end

    always_comb begin
        hit = 1'b0;
        cfg = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (int'(idx) == w) begin
                hit = 1'b1;
                cfg = per_win[w];
            end
        end
    end
endmodule

// File: rtl/card_win_space_sel.sv
module card_win_space_sel
    import card_win_pkg::*;
(
    input  space_e space,
    input  logic   active,
    output logic   sel_attr,
    output logic   sel_comm,
    output logic   sel_io
);
    always_comb begin
        sel_attr = 1'b0;
        sel_comm = 1'b0;
        sel_io   = 1'b0;
        if (active) begin
            unique case (space)
                SP_ATTR:         sel_attr = 1'b1;
                SP_IO:           sel_io   = 1'b1;
                SP_COMM, SP_ALT: sel_comm = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/card_win_seq.sv
module card_win_seq
    import card_win_pkg::*;
#(
    parameter int WAIT_CAP = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     reject,
    input  win_cfg_t cfg_in,
    input  logic     card_wait,
    output logic     drive_sel,
    output logic     drive_cmd,
    output logic     ack,
    output logic     ack_err,
    output logic     tmo,
    output logic     load
);
    localparam int WCNT_W = (WAIT_CAP > 1) ? $clog2(WAIT_CAP) : 1;
    localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(WAIT_CAP - 1);

    seq_state_e          state_q, state_d;
    logic [LEN_W-1:0]    cnt_q;
    logic [LEN_W-1:0]    pos_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    smp_q;
    logic [TIM_W-1:0]    rec_q;
    logic                wreq_q;
    logic [WCNT_W-1:0]   wcnt_q;
    logic                err_q;

    logic strobe_last, hit_sample;
    assign strobe_last = (pos_q == len_q);
    assign hit_sample  = wreq_q && (pos_q == smp_q) && card_wait;
    assign load        = (state_q == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = reject ? ST_DONE : ST_SETUP;
            ST_SETUP:   if (cnt_q == '0) state_d = ST_STROBE;
            ST_STROBE: begin
                if (hit_sample)       state_d = ST_WAIT;
                else if (strobe_last) state_d = ST_RECOVER;
            end
            ST_WAIT: begin
                if (!card_wait)            state_d = strobe_last ? ST_RECOVER : ST_STROBE;
                else if (wcnt_q == WLAST)  state_d = ST_TMO;
            end
            ST_TMO:     state_d = ST_RECOVER;
            ST_RECOVER: if (cnt_q == '0) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and per-access timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pos_q  <= '0;
            len_q  <= '0;
            smp_q  <= '0;
            rec_q  <= '0;
            wreq_q <= 1'b0;
            wcnt_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    err_q  <= reject;
                    cnt_q  <= LEN_W'(cfg_in.dly);
                    len_q  <= cfg_in.len;
                    rec_q  <= cfg_in.rec;
                    wreq_q <= cfg_in.wreq;
                    smp_q  <= (LEN_W'(cfg_in.wdly) > cfg_in.len) ? cfg_in.len
                                                                 : LEN_W'(cfg_in.wdly);
                    pos_q  <= '0;
                end
                ST_SETUP: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                ST_STROBE: begin
                    if (hit_sample)       wcnt_q <= '0;
                    else if (strobe_last) cnt_q  <= LEN_W'(rec_q);
                    else                  pos_q  <= pos_q + 1'b1;
                end
                ST_WAIT: begin
                    if (!card_wait) begin
                        if (strobe_last) cnt_q <= LEN_W'(rec_q);
                        else             pos_q <= pos_q + 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_TMO: begin
                    err_q <= 1'b1;
                    cnt_q <= LEN_W'(rec_q);
                end
                ST_RECOVER: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        drive_sel = 1'b0;
        drive_cmd = 1'b0;
        ack       = 1'b0;
        ack_err   = 1'b0;
        tmo       = 1'b0;
        unique case (state_q)
            ST_SETUP:           drive_sel = 1'b1;
            ST_STROBE, ST_WAIT: begin
                drive_sel = 1'b1;
                drive_cmd = 1'b1;
            end
            ST_TMO:             tmo = 1'b1;
            ST_DONE: begin
                ack     = 1'b1;
                ack_err = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/card_window_mapper.sv
module card_window_mapper
    import card_win_pkg::*;
#(
    parameter  int NWIN      = 3,
    parameter  int PAGE_BITS = 20,
    parameter  int WAIT_CAP  = 256,
    localparam int WSEL_W    = $clog2(NWIN + 1),
    localparam int HOST_AW   = WSEL_W + PAGE_BITS,
    localparam int CARD_AW   = BASE_W + PAGE_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    port_en,
    input  logic [NWIN*CTL_W-1:0]   win_ctl_a,
    input  logic [NWIN*CTL_W-1:0]   win_ctl_b,
    input  logic                    host_req,
    input  logic [HOST_AW-1:0]      host_addr,
    output logic                    host_ack,
    output logic                    host_err,
    output logic [CARD_AW-1:0]      card_addr,
    output logic                    card_sel_attr,
    output logic                    card_sel_comm,
    output logic                    card_sel_io,
    output logic                    card_cmd,
    input  logic                    card_wait,
    output logic                    card_timeout
);
    win_cfg_t             cfg_now;
    logic                 win_hit;
    logic                 seq_load;
    logic                 drive_sel;
    space_e               space_q;
    logic [CARD_AW-1:0]   addr_q;

    card_win_decode #(
        .NWIN(NWIN), .PAGE_BITS(PAGE_BITS), .WSEL_W(WSEL_W)
    ) u_dec (
        .ctl_a(win_ctl_a),
        .ctl_b(win_ctl_b),
        .addr (host_addr),
        .hit  (win_hit),
        .cfg  (cfg_now)
    );

    card_win_seq #(.WAIT_CAP(WAIT_CAP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (host_req),
        .reject   (!win_hit || !port_en),
        .cfg_in   (cfg_now),
        .card_wait(card_wait),
        .drive_sel(drive_sel),
        .drive_cmd(card_cmd),
        .ack      (host_ack),
        .ack_err  (host_err),
        .tmo      (card_timeout),
        .load     (seq_load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            space_q <= SP_ATTR;
        end else if (seq_load && win_hit && port_en) begin
            addr_q  <= {cfg_now.base, host_addr[PAGE_BITS-1:0]};
            space_q <= cfg_now.space;
        end
    end

    assign card_addr = addr_q;

    card_win_space_sel u_sel (
        .space   (space_q),
        .active  (drive_sel),
        .sel_attr(card_sel_attr),
        .sel_comm(card_sel_comm),
        .sel_io  (card_sel_io)
    );
endmodule

// File: rtl/card_window_mapper_chk.sv
module card_window_mapper_chk #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_ack,
    input logic          host_err,
    input logic [AW-1:0] card_addr,
    input logic          card_sel_attr,
    input logic          card_sel_comm,
    input logic          card_sel_io,
    input logic          card_cmd,
    input logic          card_timeout
);
    logic [2:0] sel;
    assign sel = {card_sel_io, card_sel_comm, card_sel_attr};

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    a_r3_cmd_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        card_cmd |-> ($countones(sel) == 1));

    a_r4_sel_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_cmd) |-> ($past(sel) != 3'b000));

    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    a_r10_ack_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (!card_cmd && sel == 3'b000));

    a_r9_tmo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        card_timeout |-> (!card_cmd && !host_ack)) ;

    a_r9_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
        card_timeout |=> (!card_timeout && !card_cmd));

    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        card_cmd |=> (!card_cmd || $stable(card_addr)));

    a_r6_err_only_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);
endmodule

bind card_window_mapper card_window_mapper_chk #(.AW(CARD_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ack     (host_ack),
    .host_err     (host_err),
    .card_addr    (card_addr),
    .card_sel_attr(card_sel_attr),
    .card_sel_comm(card_sel_comm),
    .card_sel_io  (card_sel_io),
    .card_cmd     (card_cmd),
    .card_timeout (card_timeout)
);

// File: tb/sim_card_window_mapper.sv
module sim_card_window_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b1;
    logic [47:0] win_ctl_a = '0;
    logic [47:0] win_ctl_b = '0;
    logic        host_req = 1'b0;
    logic [21:0] host_addr = '0;
    logic        host_ack, host_err;
    logic [25:0] card_addr;
    logic        card_sel_attr, card_sel_comm, card_sel_io, card_cmd;
    logic        card_wait = 1'b0;
    logic        card_timeout;

    int n_checks = 0;
    int n_fail   = 0;

    // results of the last access
    int          r_pre, r_cmd, r_post_sel, r_lat, r_tmo, r_err;
    logic [25:0] r_addr;
    logic [2:0]  r_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_window_mapper u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .win_ctl_a(win_ctl_a), .win_ctl_b(win_ctl_b),
        .host_req(host_req), .host_addr(host_addr),
        .host_ack(host_ack), .host_err(host_err),
        .card_addr(card_addr),
        .card_sel_attr(card_sel_attr), .card_sel_comm(card_sel_comm),
        .card_sel_io(card_sel_io), .card_cmd(card_cmd),
        .card_wait(card_wait), .card_timeout(card_timeout)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word_a(input logic [5:0] base, input logic [1:0] sp,
                                           input logic [1:0] dly, input logic [4:0] len);
        return {1'b0, len, dly, sp, base};
    endfunction

    function automatic logic [15:0] word_b(input logic [1:0] rec, input logic [1:0] wdly,
                                           input logic wreq);
        return {11'b0, rec, wdly, wreq};
    endfunction

    task automatic set_win(input int w, input logic [15:0] a, input logic [15:0] b);
        win_ctl_a[w*16 +: 16] = a;
        win_ctl_b[w*16 +: 16] = b;
    endtask

    // one access; rel_k > 0 drops card_wait after that many strobe cycles
    task automatic access(input logic [21:0] addr, input logic wait_lvl, input int rel_k);
        int  cyc;
        bit  done;
        @(negedge clk);
        card_wait  = wait_lvl;
        host_addr  = addr;
        host_req   = 1'b1;
        r_pre = 0; r_cmd = 0; r_post_sel = 0; r_lat = -1; r_tmo = 0; r_err = -1;
        r_addr = '0; r_sel = '0;
        cyc = 0; done = 0;
        while (!done) begin
            @(posedge clk); #1;
            cyc++;
            if (card_cmd) begin
                if (r_cmd == 0) begin
                    r_addr = card_addr;
                    r_sel  = {card_sel_io, card_sel_comm, card_sel_attr};
                end
                r_cmd++;
            end else if ({card_sel_io, card_sel_comm, card_sel_attr} != 3'b000) begin
                if (r_cmd == 0) r_pre++;
                else            r_post_sel++;
            end
            if (card_timeout) r_tmo++;
            if (rel_k > 0 && r_cmd == rel_k) card_wait = 1'b0;
            if (host_ack) begin
                r_lat = cyc; r_err = int'(host_err); done = 1;
                host_req = 1'b0; card_wait = 1'b0;
            end
            if (cyc > 2000) begin
                chk("access hang", cyc, 0);
                done = 1; host_req = 1'b0;
            end
        end
        @(posedge clk); #1;
        chk("R6 ack one cycle", int'(host_ack), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ack", int'(host_ack), 0);
        chk("R1 err", int'(host_err), 0);
        chk("R1 cmd", int'(card_cmd), 0);
        chk("R1 tmo", int'(card_timeout), 0);
        chk("R1 sel", {card_sel_io, card_sel_comm, card_sel_attr}, 0);
    endtask

    task automatic t_common_w0();
        set_win(0, word_a(6'h2A, 2'b01, 2'd1, 5'd3), word_b(2'd2, 2'd0, 1'b0));
        access({2'd0, 20'hABCDE}, 1'b0, 0);
        chk("R2 addr w0", r_addr, {6'h2A, 20'hABCDE});
        chk("R3 sel common", r_sel, 3'b010);
        chk("R4 setup cycles", r_pre, 2);
        chk("R5 strobe cycles", r_cmd, 4);
        chk("R6 latency", r_lat, 1 + 3 + 2 + 4);
        chk("R6 no err", r_err, 0);
        chk("R6 no sel in recover", r_post_sel, 0);
    endtask

    task automatic t_attr_w1_min();
        set_win(1, word_a(6'h3F, 2'b00, 2'd0, 5'd0), word_b(2'd0, 2'd0, 1'b0));
        access({2'd1, 20'h00001}, 1'b0, 0);
        chk("R2 addr w1", r_addr, {6'h3F, 20'h00001});
        chk("R3 sel attr", r_sel, 3'b001);
        chk("R4 setup min", r_pre, 1);
        chk("R5 strobe min", r_cmd, 1);
        chk("R6 latency min", r_lat, 4);
    endtask

    task automatic t_io_w2_max();
        set_win(2, word_a(6'h00, 2'b10, 2'd3, 5'd31), word_b(2'd3, 2'd0, 1'b0));
        access({2'd2, 20'hFFFFF}, 1'b0, 0);
        chk("R2 addr w2", r_addr, {6'h00, 20'hFFFFF});
        chk("R3 sel io", r_sel, 3'b100);
        chk("R4 setup max", r_pre, 4);
        chk("R5 strobe max", r_cmd, 32);
        chk("R6 latency max", r_lat, 3 + 31 + 3 + 4);
    endtask

    task automatic t_alias_space();
        set_win(0, word_a(6'h05, 2'b11, 2'd0, 5'd2), word_b(2'd1, 2'd0, 1'b0));
        access({2'd0, 20'h12345}, 1'b0, 0);
        chk("R3 sel alias 11 common", r_sel, 3'b010);
        chk("R2 addr reprogrammed", r_addr, {6'h05, 20'h12345});
    endtask

    task automatic t_wait_stretch();
        // wdelay 2, length 5: sample at strobe cycle 2; release after 8 strobe cycles
        set_win(1, word_a(6'h11, 2'b01, 2'd0, 5'd5), word_b(2'd0, 2'd2, 1'b1));
        access({2'd1, 20'h0F0F0}, 1'b1, 8);
        chk("R7 stretched strobe", r_cmd, 8 + 5 - 2);
        chk("R7 stretched latency", r_lat, 0 + 0 + 3 + 11);
        chk("R7 no timeout", r_tmo, 0);
        chk("R7 no err", r_err, 0);
        chk("R11 addr during stretch", r_addr, {6'h11, 20'h0F0F0});
    endtask

    task automatic t_wait_late_sample();
        // wdelay 3 > length 1: sample falls on last strobe cycle
        set_win(1, word_a(6'h11, 2'b01, 2'd0, 5'd1), word_b(2'd0, 2'd3, 1'b1));
        access({2'd1, 20'h00010}, 1'b1, 5);
        chk("R7 late sample strobe", r_cmd, 5);
        chk("R7 late sample err", r_err, 0);
    endtask

    task automatic t_wait_ignored();
        set_win(2, word_a(6'h01, 2'b10, 2'd0, 5'd4), word_b(2'd0, 2'd1, 1'b0));
        access({2'd2, 20'h00000}, 1'b1, 0);
        chk("R8 strobe unaffected", r_cmd, 5);
        chk("R8 latency unaffected", r_lat, 0 + 4 + 0 + 4);
        chk("R8 no timeout", r_tmo, 0);
    endtask

    task automatic t_timeout();
        set_win(0, word_a(6'h07, 2'b00, 2'd0, 5'd2), word_b(2'd1, 2'd0, 1'b1));
        access({2'd0, 20'h00042}, 1'b1, 0);
        chk("R9 strobe until cap", r_cmd, 1 + 256);
        chk("R9 one timeout pulse", r_tmo, 1);
        chk("R9 err ack", r_err, 1);
        chk("R9 latency", r_lat, 1 + 1 + 256 + 1 + 2 + 1);
        chk("R9 no sel after timeout", r_post_sel, 0);
    endtask

    task automatic t_miss_window();
        access({2'd3, 20'h00000}, 1'b0, 0);
        chk("R10 miss ack next cycle", r_lat, 1);
        chk("R10 miss err", r_err, 1);
        chk("R10 miss no strobe", r_cmd, 0);
        chk("R10 miss no sel", r_pre, 0);
    endtask

    task automatic t_port_off();
        port_en = 1'b0;
        access({2'd0, 20'h00000}, 1'b0, 0);
        chk("R10 disabled err", r_err, 1);
        chk("R10 disabled latency", r_lat, 1);
        chk("R10 disabled no strobe", r_cmd + r_pre, 0);
        port_en = 1'b1;
        set_win(0, word_a(6'h2A, 2'b01, 2'd1, 5'd3), word_b(2'd2, 2'd0, 1'b0));
        access({2'd0, 20'h00001}, 1'b0, 0);
        chk("R10 recovery after error", r_lat, 10);
        chk("R10 recovery err clear", r_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_common_w0();
        t_attr_w1_min();
        t_io_w2_max();
        t_alias_space();
        t_wait_stretch();
        t_wait_late_sample();
        t_wait_ignored();
        t_timeout();
        t_miss_window();
        t_port_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule